// File: doc/BRIEF.md
# Write-In-Progress Status Reporter

This block sits beside the write controller of a byte-wide non-volatile memory and tells a host, three ways at once, that an internal program cycle is still running. An active-low open-drain style busy line is pulled for as long as the controller reports the cycle. A read taken during the cycle returns a polling bit equal to the complement of the most significant bit of the last byte loaded. In the same read, a toggle bit changes value from one read to the next. When the controller is idle, reads return the array contents unchanged.

The host's chip-enable, output-enable and write-enable strobes, plus an active-low read-inhibit input, are sampled on the block clock. A read is a sampled cycle with chip enable and output enable low, write enable high and the inhibit input high. Read data and its drive enable are registered, so they appear one clock after the sampled read. The busy pull enable follows the controller's busy flag after `RB_LAT` clocks. Bit positions of the polling and toggle bits are parameters, 7 and 6 by default.

Top module: `wip_status`

## Requirements
- R1: While `busy_i` has been high for `RB_LAT` (default 1) sampled clocks, `rb_pull_o` is 1 (line pulled low).
- R2: `RB_LAT` clocks after `busy_i` is sampled low, `rb_pull_o` is 0 (line released). After reset it is 0.
- R3: In a read sampled while `busy_i` is high, bit 7 of `rd_data_o` equals the inverse of `wr_last_msb_i`.
- R4: In reads sampled while busy, bit 6 is 1 on the first read event after busy rises, and inverts on each later read event. A read event is a sampled read whose previous sampled cycle was not a read.
- R5: A read held over several clocks is a single event: bit 6 keeps its value while the strobes stay asserted.
- R6: In a read sampled while `busy_i` is low, `rd_data_o` equals `arr_data_i` on all bits.
- R7: In a read sampled while busy, all bits other than 7 and 6 equal `arr_data_i`.
- R8: While `inhibit_ni` is sampled low, no read is taken: `rd_drive_o` is 0 and `rd_data_o` is 0 on the next clock, and no toggle event is counted.
- R9: `rd_drive_o` is 1 exactly one clock after a sampled read. `rd_data_o` is 0 whenever `rd_drive_o` is 0. After reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Program cycle in progress, from the write controller |
| wr_last_msb_i | input | 1 | Most significant bit of the last byte loaded |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| inhibit_ni | input | 1 | Read inhibit, active low |
| arr_data_i | input | DW | Array data at the presented address |
| rd_data_o | output | DW | Read data to the pad driver |
| rd_drive_o | output | 1 | Pad output enable |
| rb_pull_o | output | 1 | Busy line pull-down enable |

## Verification
The bench targets a read that starts on the same clock busy rises, which must return 1 on the toggle bit; a design that kept a stale toggle state would return 0 there. It holds output enable low across many clocks, where a design toggling on level rather than edge would flip bit 6 every clock. It drops busy in the middle of a held read; a design that kept overriding bits 7 and 6 would report a finished cycle as still running. It also pulses the inhibit input during reads; a design that ignored it would drive data and could advance the toggle.

// File: rtl/wip_pkg.sv
package wip_pkg;
   localparam int WIP_DW_DEF     = 8;
   localparam int WIP_POLL_DEF   = 7;
   localparam int WIP_TGL_DEF    = 6;
   localparam int WIP_RB_LAT_DEF = 1;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic inh_n;
   } wip_pins_t;

   function automatic logic wip_is_read(input wip_pins_t p);
      return !p.ce_n && !p.oe_n && p.we_n && p.inh_n;
   endfunction
endpackage

// File: rtl/wip_strobe.sv
module wip_strobe
   import wip_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  wip_pins_t pins_i,
   output logic      strobe_o,
   output logic      event_o
);
   logic strobe_q;

   assign strobe_o = wip_is_read(pins_i);
   assign event_o  = strobe_o && !strobe_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) strobe_q <= 1'b0;
      else         strobe_q <= strobe_o;
   end

   assert_inhibit_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pins_i.inh_n |-> !event_o);
endmodule

// File: rtl/wip_toggle.sv
module wip_toggle (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic busy_i,
   input  logic event_i,
   output logic bit_o
);
   logic next_q;
   logic shown_q;

   assign bit_o = event_i ? next_q : shown_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         next_q  <= 1'b1;
         shown_q <= 1'b1;
      end else if (!busy_i) begin
         next_q  <= 1'b1;
         shown_q <= 1'b1;
      end else if (event_i) begin
         shown_q <= next_q;
         next_q  <= ~next_q;
      end
   end

   assert_first_read_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!busy_i) && busy_i && event_i) |-> bit_o);
   assert_hold_no_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(busy_i) && busy_i && !event_i) |-> (bit_o == $past(bit_o)));
endmodule

// File: rtl/wip_rb_delay.sv
module wip_rb_delay #(
   parameter int LAT = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic busy_i,
   output logic pull_o
);
   logic [LAT-1:0] pipe_q;

   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pipe_q <= '0;
            else         pipe_q <= busy_i;
         end
         assert_pull_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(busy_i) |-> pull_o);
         assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(!busy_i) |-> !pull_o);
      end else begin : g_chain
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pipe_q <= '0;
            else         pipe_q <= {pipe_q[LAT-2:0], busy_i};
         end
      end
   endgenerate

   assign pull_o = pipe_q[LAT-1];
endmodule

// File: rtl/wip_status.sv
module wip_status
   import wip_pkg::*;
#(
   parameter int DW       = WIP_DW_DEF,
   parameter int POLL_BIT = WIP_POLL_DEF,
   parameter int TGL_BIT  = WIP_TGL_DEF,
   parameter int RB_LAT   = WIP_RB_LAT_DEF
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          busy_i,
   input  logic          wr_last_msb_i,
   input  logic          ce_ni,
   input  logic          oe_ni,
   input  logic          we_ni,
   input  logic          inhibit_ni,
   input  logic [DW-1:0] arr_data_i,
   output logic [DW-1:0] rd_data_o,
   output logic          rd_drive_o,
   output logic          rb_pull_o
);
   initial begin
      assert (DW >= 2) else $error("wip_status: DW must be at least 2");
      assert (POLL_BIT < DW && TGL_BIT < DW) else $error("wip_status: status bit out of range");
      assert (POLL_BIT != TGL_BIT) else $error("wip_status: status bits must differ");
      assert (RB_LAT >= 1) else $error("wip_status: RB_LAT must be at least 1");
   end

   wip_pins_t     pins;
   logic          strobe;
   logic          rd_event;
   logic          tgl_bit;
   logic [DW-1:0] data_nx;

   assign pins = '{ce_n: ce_ni, oe_n: oe_ni, we_n: we_ni, inh_n: inhibit_ni};

   wip_strobe u_strobe (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pins_i  (pins),
      .strobe_o(strobe),
      .event_o (rd_event)
   );

   wip_toggle u_toggle (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .busy_i (busy_i),
      .event_i(rd_event),
      .bit_o  (tgl_bit)
   );

   wip_rb_delay #(.LAT(RB_LAT)) u_rb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .busy_i(busy_i),
      .pull_o(rb_pull_o)
   );

   generate
      for (genvar b = 0; b < DW; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign data_nx[b] = busy_i ? ~wr_last_msb_i : arr_data_i[b];
         end else if (b == TGL_BIT) begin : g_tgl
            assign data_nx[b] = busy_i ? tgl_bit : arr_data_i[b];
         end else begin : g_pass
            assign data_nx[b] = arr_data_i[b];
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_data_o  <= '0;
         rd_drive_o <= 1'b0;
      end else begin
         rd_data_o  <= strobe ? data_nx : '0;
         rd_drive_o <= strobe;
      end
   end

   assert_drive_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_drive_o == $past(!ce_ni && !oe_ni && we_ni && inhibit_ni));
   assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_drive_o |-> (rd_data_o == '0));
   assert_inhibit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!inhibit_ni) |-> (!rd_drive_o && rd_data_o == '0));
   assert_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_drive_o && $past(busy_i)) |-> (rd_data_o[POLL_BIT] == !$past(wr_last_msb_i)));
   assert_idle_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_drive_o && $past(!busy_i)) |-> (rd_data_o == $past(arr_data_i)));
endmodule

// File: tb/wip_status_tb.sv
module wip_status_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          busy = 1'b0, msb = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, inh_n = 1'b1;
   logic [DW-1:0] arr = '0;
   logic [DW-1:0] rd_data;
   logic          rd_drive, rb_pull;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic m_tgl = 1'b1, m_shown = 1'b1, m_sq = 1'b0, m_rb = 1'b0;
   logic [DW-1:0] e_data = '0;
   logic          e_drive = 1'b0;

   always #10 clk = ~clk;

   wip_status u_dut (
      .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .wr_last_msb_i(msb),
      .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .inhibit_ni(inh_n),
      .arr_data_i(arr), .rd_data_o(rd_data), .rd_drive_o(rd_drive), .rb_pull_o(rb_pull)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic is_read();
      return !ce_n && !oe_n && we_n && inh_n;
   endfunction

   // advance one clock, update model from sampled inputs, compare after edge
   task automatic step();
      logic s, ev;
      @(posedge clk);
      s  = is_read();
      ev = s && !m_sq;
      if (!rst_n) begin
         e_data = '0; e_drive = 1'b0; m_tgl = 1'b1; m_shown = 1'b1; m_sq = 1'b0; m_rb = 1'b0;
      end else begin
         e_drive = s;
         if (!s) e_data = '0;
         else if (!busy) e_data = arr;
         else begin
            e_data = arr;
            e_data[7] = ~msb;
            e_data[6] = ev ? m_tgl : m_shown;
         end
         if (!busy) begin m_tgl = 1'b1; m_shown = 1'b1; end
         else if (ev) begin m_shown = m_tgl; m_tgl = ~m_tgl; end
         m_sq = s;
         m_rb = busy;
      end
      #2;
      chk(rd_drive == e_drive, "R9 drive", rd_drive, e_drive);
      chk(rb_pull == m_rb, m_rb ? "R1 pull" : "R2 release", rb_pull, m_rb);
      chk(rd_data[7] == e_data[7], "R3 poll bit", rd_data, e_data);
      chk(rd_data[6] == e_data[6], "R4/R5 toggle bit", rd_data, e_data);
      chk(rd_data[5:0] == e_data[5:0], "R7 low bits", rd_data, e_data);
      if (!inh_n) chk(!rd_drive && rd_data == '0, "R8 inhibit", rd_data, 0);
      if (e_drive && !busy) chk(rd_data == arr, "R6 idle read", rd_data, arr);
   endtask

   task automatic drive(input logic b, input logic c, input logic o, input logic w, input logic i);
      @(negedge clk);
      busy = b; ce_n = c; oe_n = o; we_n = w; inh_n = i;
      arr = DW'($urandom);
   endtask

   task automatic read_pulse(input logic b, input logic expect6, input string tag);
      drive(b, 0, 0, 1, 1); step();
      chk(rd_drive && rd_data[6] == expect6, tag, rd_data[6], expect6);
      drive(b, 1, 1, 1, 1); step();
   endtask

   initial begin
      #(20 * 190000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0107));
      step(); step();
      chk(rd_data == '0 && !rd_drive && !rb_pull, "R9 R2 reset state", rd_data, 0);
      @(negedge clk); rst_n = 1'b1;
      step();

      // idle read returns array
      drive(0, 0, 0, 1, 1); step();
      drive(0, 1, 1, 1, 1); step();

      // program cycle: read on same edge busy rises, then successive reads
      msb = 1'b1;
      read_pulse(1, 1'b1, "R4 first read is 1");
      read_pulse(1, 1'b0, "R4 second read flips");
      read_pulse(1, 1'b1, "R4 third read flips");
      // held read: no toggle across clocks
      drive(1, 0, 0, 1, 1); step();
      for (int k = 0; k < 6; k++) begin
         drive(1, 0, 0, 1, 1); step();
         chk(rd_data[6] == 1'b0, "R5 held read stable", rd_data[6], 0);
      end
      // busy drops mid-held read: array data returns
      drive(0, 0, 0, 1, 1); step();
      chk(rd_data == arr, "R6 busy ended", rd_data, arr);
      drive(0, 1, 1, 1, 1); step();

      // inhibit during busy read: no event, so next read still shows 1
      msb = 1'b0;
      drive(1, 1, 1, 1, 1); step();
      drive(1, 0, 0, 1, 0); step();
      drive(1, 0, 0, 1, 0); step();
      drive(1, 1, 1, 1, 1); step();
      read_pulse(1, 1'b1, "R8 inhibited read not counted");
      // write strobe low is not a read
      drive(1, 0, 0, 0, 1); step();
      chk(!rd_drive, "R9 write not read", rd_drive, 0);
      drive(0, 1, 1, 1, 1); step();
      step();

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         logic b;
         b = busy;
         if ($urandom_range(0, 39) == 0) b = ~busy;
         if ($urandom_range(0, 49) == 0) msb = $urandom;
         drive(b, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
               $urandom_range(0, 7) != 0, $urandom_range(0, 9) != 0);
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule